// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its edges over a known time window. A control bit arms a measurement and also acts as the counter reset. After arming, the block waits a fixed number of millisecond ticks so that the signal can settle. It then opens a gate whose length comes from a two-bit select. It counts qualified IF edges into a saturating binary register and raises a completion flag when the gate closes. The result stays held until the control bit is cleared.

The block also drives a shared open-drain status pin through a small source multiplexer. A three-bit select chooses one of three things to drive the pin low: loss of synthesizer lock, completion of the measurement, or stereo detection. Every other select code leaves the pin released. While the serial port is active, the serial port owns the pin instead.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `count_o` is 0, `done_o` is 0 and `pin_low_o` is 0 (pin released).
- R2: While `start_i` is 0, the counter reads 0 and `done_o` is 0, starting from the clock edge after `start_i` is sampled low.
- R3: Only a 0-to-1 change of `start_i` arms a measurement. After arming, `count_o` rises by one for every clock edge in the gate that sees `if_en_i` high, and never by more than one per cycle.
- R4: The count saturates at all ones (2^CNT_W-1) and does not wrap.
- R5: The gate lasts GATE_BASE<<`gate_sel_i` ticks, which is 4, 8, 16 or 32 ticks for codes 0 to 3. The select is sampled on the arming edge.
- R6: A wait of WAIT_TICKS (4) ticks follows arming. IF edges during the wait are not counted.
- R7: When the gate closes, `done_o` goes to 1. `done_o` and `count_o` then hold while `start_i` stays 1.
- R8: Status pin, registered with one cycle of delay: select 3'b001 pulls the pin low on `unlock_i`, 3'b010 pulls it low on completion, and 3'b110 pulls it low on `stereo_i`. All other codes release the pin.
- R9: While `ser_active_i` is 1, the select is overridden. With `ser_rd_i`=0 the pin is released. With `ser_rd_i`=1 it is pulled low exactly when `ser_bit_i` is 0.
- R10: While `inhibit_i` is 1, no edge is counted and the wait/gate timer ignores ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arm on rising edge; counter held cleared while low |
| gate_sel_i | input | SEL_W | Gate length select |
| if_en_i | input | 1 | One-cycle qualifier per IF edge |
| tick_i | input | 1 | Millisecond tick |
| inhibit_i | input | 1 | Synthesizer inhibited: freeze counting and timing |
| pin_sel_i | input | 3 | Status pin source select |
| unlock_i | input | 1 | Synthesizer unlock indication |
| stereo_i | input | 1 | Stereo detected indication |
| ser_active_i | input | 1 | Serial port active (chip enable high) |
| ser_rd_i | input | 1 | Serial port in read-out direction |
| ser_bit_i | input | 1 | Current read-out data bit |
| count_o | output | CNT_W | Held count |
| done_o | output | 1 | Measurement complete |
| pin_low_o | output | 1 | 1 pulls the open-drain status pin low |

## Verification
The bench targets the exact edge count at each gate length. A design that counted during the wait, or that was off by one tick at gate close, would report a count that differs from gate ticks times tick period. A second test with alternating qualifiers catches a design that counts cycles instead of qualified edges. A long gate drives the count past full scale, and a wrapping counter would return a small number there. The pin tests hold the other status sources high under the wrong select code, and they assert the serial override while completion is pending, so a decode or priority slip shows up as a wrongly pulled pin.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam logic [2:0] PSEL_UNLOCK = 3'b001;
  localparam logic [2:0] PSEL_DONE   = 3'b010;
  localparam logic [2:0] PSEL_STEREO = 3'b110;
endpackage

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
  import ifc_pkg::*;
#(
  parameter int WAIT_TICKS = 4,
  parameter int GATE_BASE  = 4,
  parameter int SEL_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  input  logic             inhibit_i,
  output logic             gate_o,
  output logic             done_o
);
  localparam int MAX_GATE = GATE_BASE << ((1 << SEL_W) - 1);
  localparam int MAX_T    = (MAX_GATE > WAIT_TICKS) ? MAX_GATE : WAIT_TICKS;
  localparam int TW       = $clog2(MAX_T + 1);

  phase_e           phase_q;
  logic [TW-1:0]    tcnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             start_q;
  logic             arm;
  logic [TW-1:0]    gate_len;

  assign arm      = start_i & ~start_q;
  assign gate_len = TW'(GATE_BASE) << sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tcnt_q  <= '0;
      sel_q   <= '0;
    end else if (!start_i) begin
      phase_q <= PH_IDLE;
      tcnt_q  <= '0;
    end else if (arm) begin
      phase_q <= PH_WAIT;
      tcnt_q  <= '0;
      sel_q   <= sel_i;
    end else if (tick_i && !inhibit_i) begin
      unique case (phase_q)
        PH_WAIT: begin
          if (tcnt_q == TW'(WAIT_TICKS - 1)) begin
            phase_q <= PH_GATE;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        PH_GATE: begin
          if (tcnt_q == gate_len - 1'b1) begin
            phase_q <= PH_DONE;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign gate_o = (phase_q == PH_GATE);
  assign done_o = (phase_q == PH_DONE);
endmodule

// File: rtl/ifc_edge_counter.sv
module ifc_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (inc_i && !full) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ifc_pin_mux.sv
module ifc_pin_mux
  import ifc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       unlock_i,
  input  logic       stereo_i,
  input  logic       done_i,
  input  logic       ser_active_i,
  input  logic       ser_rd_i,
  input  logic       ser_bit_i,
  output logic       pin_low_o
);
  logic pull_d, pull_q;

  always_comb begin
    if (ser_active_i) begin
      pull_d = ser_rd_i & ~ser_bit_i;
    end else begin
      unique case (sel_i)
        PSEL_UNLOCK: pull_d = unlock_i;
        PSEL_DONE:   pull_d = done_i;
        PSEL_STEREO: pull_d = stereo_i;
        default:     pull_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= 1'b0;
    else         pull_q <= pull_d;
  end

  assign pin_low_o = pull_q;
endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W      = 20,
  parameter int SEL_W      = 2,
  parameter int WAIT_TICKS = 4,
  parameter int GATE_BASE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] gate_sel_i,
  input  logic             if_en_i,
  input  logic             tick_i,
  input  logic             inhibit_i,
  input  logic [2:0]       pin_sel_i,
  input  logic             unlock_i,
  input  logic             stereo_i,
  input  logic             ser_active_i,
  input  logic             ser_rd_i,
  input  logic             ser_bit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             pin_low_o
);
  logic gate, done;

  ifc_gate_timer #(
    .WAIT_TICKS(WAIT_TICKS),
    .GATE_BASE (GATE_BASE),
    .SEL_W     (SEL_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .sel_i    (gate_sel_i),
    .tick_i   (tick_i),
    .inhibit_i(inhibit_i),
    .gate_o   (gate),
    .done_o   (done)
  );

  ifc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~start_i),
    .inc_i (gate & if_en_i & ~inhibit_i),
    .cnt_o (count_o)
  );

  ifc_pin_mux u_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (pin_sel_i),
    .unlock_i    (unlock_i),
    .stereo_i    (stereo_i),
    .done_i      (done),
    .ser_active_i(ser_active_i),
    .ser_rd_i    (ser_rd_i),
    .ser_bit_i   (ser_bit_i),
    .pin_low_o   (pin_low_o)
  );

  assign done_o = done;
endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             inhibit_i,
  input logic [2:0]       pin_sel_i,
  input logic             ser_active_i,
  input logic             ser_rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             pin_low_o
);
  a_r2_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (count_o == '0) && !done_o);

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (&count_o)) |=> (&count_o) || !$past(start_i));

  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o && $stable(count_o));

  a_r10_inhibit_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && start_i) |=> $stable(count_o) && !$rose(done_o));

  a_r8_pin_default_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_active_i && pin_sel_i != 3'b001 && pin_sel_i != 3'b010 && pin_sel_i != 3'b110)
      |=> !pin_low_o);

  a_r9_ser_write_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_active_i && !ser_rd_i) |=> !pin_low_o);
endmodule

bind if_gate_counter if_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .inhibit_i   (inhibit_i),
  .pin_sel_i   (pin_sel_i),
  .ser_active_i(ser_active_i),
  .ser_rd_i    (ser_rd_i),
  .count_o     (count_o),
  .done_o      (done_o),
  .pin_low_o   (pin_low_o)
);

// File: tb/if_gate_counter_test.sv
module if_gate_counter_test;
  localparam int CW    = 8;    // narrow so saturation is reachable
  localparam int TICKP = 10;   // clocks per tick

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    gate_sel_i = '0;
  logic          if_en_i = 1'b0;
  logic          tick_i = 1'b0;
  logic          inhibit_i = 1'b0;
  logic [2:0]    pin_sel_i = '0;
  logic          unlock_i = 1'b0;
  logic          stereo_i = 1'b0;
  logic          ser_active_i = 1'b0;
  logic          ser_rd_i = 1'b0;
  logic          ser_bit_i = 1'b0;
  logic [CW-1:0] count_o;
  logic          done_o;
  logic          pin_low_o;

  int    n_chk = 0, n_fail = 0;
  bit    alt_mode = 1'b0;
  int    tph = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  if_gate_counter #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .gate_sel_i(gate_sel_i),
    .if_en_i(if_en_i), .tick_i(tick_i), .inhibit_i(inhibit_i),
    .pin_sel_i(pin_sel_i), .unlock_i(unlock_i), .stereo_i(stereo_i),
    .ser_active_i(ser_active_i), .ser_rd_i(ser_rd_i), .ser_bit_i(ser_bit_i),
    .count_o(count_o), .done_o(done_o), .pin_low_o(pin_low_o)
  );

  always @(negedge clk) begin
    tph     = (tph == TICKP - 1) ? 0 : tph + 1;
    tick_i  = (tph == 0);
    if_en_i = alt_mode ? ~if_en_i : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compare on each completion
  always begin
    @(posedge done_o);
    @(negedge clk);
    if (exp_q.size() == 0) begin
      check(1'b0, "R7 unexpected done", 1, 0);
    end else begin
      automatic int    e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(count_o == CW'(e), t, int'(count_o), e);
    end
  end

  task automatic measure(input int sel, input bit alt, input int exp, input string tag);
    gate_sel_i = 2'(sel);
    alt_mode   = alt;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) gate_sel_i = ~gate_sel_i;  // sampled only at arming
    wait (done_o);
    repeat (3) @(negedge clk);
    begin
      automatic int held = int'(count_o);
      repeat (30) @(negedge clk);
      check(done_o && int'(count_o) == held, "R7 result held", int'(count_o), held);
    end
  endtask

  task automatic stop_meas();
    @(negedge clk) start_i = 1'b0;
    repeat (2) @(negedge clk);
    check(count_o == '0 && !done_o, "R2 cleared while start low", int'(count_o), 0);
  endtask

  function automatic int sat(input int v);
    return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(count_o == '0 && !done_o && !pin_low_o, "R1 reset state", int'(count_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R5 R6 R3: continuous qualifier, count = gate ticks * tick period
    measure(0, 1'b0, 4 * TICKP, "R5 R6 gate 4 ticks");
    stop_meas();
    measure(1, 1'b0, 8 * TICKP, "R5 R6 gate 8 ticks");
    stop_meas();
    // R3: alternating qualifier counts half the gate cycles
    measure(2, 1'b1, 16 * TICKP / 2, "R3 alternating gate 16 ticks");
    stop_meas();
    // R4: 32-tick gate overruns the narrow counter
    measure(3, 1'b0, sat(32 * TICKP), "R4 saturation gate 32 ticks");

    // R8: completion mode with result pending
    pin_sel_i = 3'b010;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b1, "R8 done pulls pin", int'(pin_low_o), 1);
    // R9: serial write direction releases, read follows data
    ser_active_i = 1'b1; ser_rd_i = 1'b0;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b0, "R9 serial write releases pin", int'(pin_low_o), 0);
    ser_rd_i = 1'b1; ser_bit_i = 1'b0;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b1, "R9 read bit 0 pulls pin", int'(pin_low_o), 1);
    ser_bit_i = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b0, "R9 read bit 1 releases pin", int'(pin_low_o), 0);
    ser_active_i = 1'b0; ser_rd_i = 1'b0;
    stop_meas();
    check(pin_low_o == 1'b0, "R8 pin released after clear", int'(pin_low_o), 0);

    // R8: completion mode released while measuring
    alt_mode = 1'b0;
    @(negedge clk) start_i = 1'b1;
    repeat (20) @(negedge clk);
    check(pin_low_o == 1'b0, "R8 pin open during count", int'(pin_low_o), 0);
    @(negedge clk) start_i = 1'b0;

    // R8: other sources
    unlock_i = 1'b1; stereo_i = 1'b1;
    pin_sel_i = 3'b001;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b1, "R8 unlock select", int'(pin_low_o), 1);
    pin_sel_i = 3'b110;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b1, "R8 stereo select", int'(pin_low_o), 1);
    pin_sel_i = 3'b011;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b0, "R8 unused code open", int'(pin_low_o), 0);
    stereo_i = 1'b0;
    pin_sel_i = 3'b110;
    repeat (2) @(negedge clk);
    check(pin_low_o == 1'b0, "R8 stereo off", int'(pin_low_o), 0);
    unlock_i = 1'b0; pin_sel_i = 3'b000;

    // R10: inhibited from arming, nothing counted, no completion
    inhibit_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    repeat (8 * TICKP * 4) @(negedge clk);
    check(count_o == '0 && !done_o, "R10 inhibit freezes", int'(count_o), 0);
    inhibit_i = 1'b0;
    stop_meas();

    // R3: holding start high after completion does not re-arm
    measure(0, 1'b0, 4 * TICKP, "R3 re-run gate 4 ticks");
    repeat (20 * TICKP) @(negedge clk);
    check(done_o && count_o == CW'(4 * TICKP), "R3 no re-arm while high", int'(count_o), 4 * TICKP);
    stop_meas();

    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule